// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A read or write command is presented as a one-cycle `cmd_valid` pulse. The pulse carries a start column, a burst-length code and an ordering select. On the following clock the first beat appears on `col`, with `beat_valid` high. The block then steps by itself once per clock until the programmed number of beats has been produced.

Fixed bursts of 2, 4 and 8 beats wrap inside the aligned block of their own size. They advance in either linear or interleaved order. Full-page bursts walk through the whole row, modulo the column count, and run until something stops them. A terminate input cuts any burst short. A fresh command on any cycle abandons the running burst and starts again from the new column. `last_beat` marks the closing beat of a fixed-length burst, so the data path can release the bank.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `beat_valid` and `last_beat` are 0 and `col` is 0.
- R2: A `cmd_valid` sampled high at a clock edge makes `beat_valid` 1 and `col` equal to the sampled `start_col` after that edge.
- R3: `burst_len` codes: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4 to 6 behave as 1 beat. A fixed burst shows exactly that many consecutive valid beats, then `beat_valid` drops.
- R4: With `interleave`=0 and length N in {2,4,8}, beat k has the column bits above log2(N) equal to the start column's. Its low log2(N) bits are (start low bits + k) mod N.
- R5: With `interleave`=1 and length N in {2,4,8}, beat k has the upper bits unchanged and its low log2(N) bits equal to the start low bits XOR k.
- R6: In full-page mode beat k is (start_col + k) mod 512. The burst continues, including past column 511 back to 0, until a terminate or a new command. `interleave` has no effect in this mode.
- R7: `last_beat` is 1 exactly on the final beat of a fixed-length burst. It is never 1 during a full-page burst.
- R8: `term` sampled high during a valid beat makes that beat the last one shown, and `beat_valid` is 0 from the next cycle. `term` while idle has no effect on the outputs.
- R9: A `cmd_valid` during a burst restarts from the new `start_col`, using the newly supplied length and order. When `cmd_valid` and `term` are high together, the command wins.
- R10: While no burst is active, `beat_valid` stays 0 and `col` keeps the column of the last beat shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Read or write command registered this cycle |
| start_col | input | 9 | Start column carried with the command |
| burst_len | input | 3 | Burst-length code (see R3) |
| interleave | input | 1 | 0 linear order, 1 interleaved order |
| term | input | 1 | Burst terminate |
| col | output | 9 | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | Current beat closes a fixed-length burst |

## Verification
The properties assume that `cmd_valid`, `term` and the command fields are synchronous to `clk` and hold steady around the rising edge. They also assume that `burst_len` is meaningful only in the cycle where `cmd_valid` is high. The bench changes every input on the falling edge and holds it for a whole period. It drives `term` only as a level across complete cycles, and it leaves the command fields unchanged while `cmd_valid` is low. Thus every input a property samples is settled and belongs to a single cycle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
   typedef enum logic [2:0] {
      LEN_1    = 3'd0,
      LEN_2    = 3'd1,
      LEN_4    = 3'd2,
      LEN_8    = 3'd3,
      LEN_PAGE = 3'd7
   } len_code_e;
endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
   parameter int COL_W = 9
) (
   input  logic [2:0]       len_code,
   output logic [COL_W-1:0] wrap_mask,
   output logic             page
);
   import colgen_pkg::*;

   always_comb begin
      page      = 1'b0;
      wrap_mask = '0;
      case (len_code)
         LEN_2:    wrap_mask = COL_W'(1);
         LEN_4:    wrap_mask = COL_W'(3);
         LEN_8:    wrap_mask = COL_W'(7);
         LEN_PAGE: begin
            wrap_mask = '1;
            page      = 1'b1;
         end
         default:  wrap_mask = '0;
      endcase
   end
endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
   parameter int COL_W         = 9,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic [COL_W-1:0] base,
   input  logic [COL_W-1:0] count,
   input  logic [COL_W-1:0] wrap_mask,
   input  logic             ilv,
   output logic [COL_W-1:0] col
);
   logic [COL_W-1:0] moved;

   generate
      if (INTERLEAVE_EN) begin : g_both_orders
         assign moved = ilv ? (base ^ count) : (base + count);
      end else begin : g_linear_only
         logic unused_ilv;
         assign unused_ilv = ilv;
         assign moved      = base + count;
      end
   endgenerate

   assign col = (base & ~wrap_mask) | (moved & wrap_mask);
endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
   parameter int COL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             term,
   input  logic             page,
   input  logic [COL_W-1:0] last_idx,
   output logic [COL_W-1:0] count,
   output logic             active
);
   logic at_end;
   assign at_end = !page && (count == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         active <= 1'b0;
      end else if (load) begin
         count  <= '0;
         active <= 1'b1;
      end else if (active) begin
         if (term || at_end) active <= 1'b0;
         else                count  <= count + COL_W'(1);
      end
   end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
   parameter int COL_W         = 9,
   parameter bit INTERLEAVE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [COL_W-1:0] start_col,
   input  logic [2:0]       burst_len,
   input  logic             interleave,
   input  logic             term,
   output logic [COL_W-1:0] col,
   output logic             beat_valid,
   output logic             last_beat
);
   localparam int MAX_FIXED = 8;
   localparam int MIN_COL_W = $clog2(MAX_FIXED) + 1;

   generate
      if (COL_W < MIN_COL_W) begin : g_bad_width
         $error("sdram_burst_colgen: COL_W must be at least %0d", MIN_COL_W);
      end
   endgenerate

   logic [COL_W-1:0] dec_mask;
   logic             dec_page;
   logic [COL_W-1:0] start_q, mask_q, count;
   logic             page_q, ilv_q, active;

   colgen_len_decode #(.COL_W(COL_W)) u_dec (
      .len_code (burst_len),
      .wrap_mask(dec_mask),
      .page     (dec_page)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         mask_q  <= '0;
         page_q  <= 1'b0;
         ilv_q   <= 1'b0;
      end else if (cmd_valid) begin
         start_q <= start_col;
         mask_q  <= dec_mask;
         page_q  <= dec_page;
         ilv_q   <= interleave & ~dec_page;
      end
   end

   colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cmd_valid),
      .term    (term),
      .page    (page_q),
      .last_idx(mask_q),
      .count   (count),
      .active  (active)
   );

   colgen_order #(.COL_W(COL_W), .INTERLEAVE_EN(INTERLEAVE_EN)) u_ord (
      .base     (start_q),
      .count    (count),
      .wrap_mask(mask_q),
      .ilv      (ilv_q),
      .col      (col)
   );

   assign beat_valid = active;
   assign last_beat  = active && !page_q && (count == mask_q);
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
   parameter int COL_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [COL_W-1:0] start_col,
   input logic [2:0]       burst_len,
   input logic             term,
   input logic [COL_W-1:0] col,
   input logic             beat_valid,
   input logic             last_beat
);
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (beat_valid && col == $past(start_col)));

   assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> beat_valid);

   assert_page_no_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && burst_len == 3'd7) |=> !last_beat);

   assert_ends_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && !cmd_valid) |=> !beat_valid);

   assert_continues_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !last_beat && !term) |=> beat_valid);

   assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && term && !cmd_valid) |=> !beat_valid);

   assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!beat_valid && !cmd_valid) |=> (!beat_valid && $stable(col)));
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .start_col (start_col),
   .burst_len (burst_len),
   .term      (term),
   .col       (col),
   .beat_valid(beat_valid),
   .last_beat (last_beat)
);

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;
   localparam real HALF = 10.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [8:0] start_col = '0;
   logic [2:0] burst_len = '0;
   logic       interleave = 1'b0;
   logic       term = 1'b0;
   logic [8:0] col;
   logic       beat_valid, last_beat;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(HALF) clk = ~clk;

   sdram_burst_colgen uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .start_col(start_col),
      .burst_len(burst_len), .interleave(interleave), .term(term),
      .col(col), .beat_valid(beat_valid), .last_beat(last_beat)
   );

   typedef struct packed {
      logic [8:0] start;
      logic [2:0] len;
      logic       ilv;
      logic [3:0] beats;
      logic [8:0] final_col;
   } vec_t;

   localparam vec_t VECS [0:8] = '{
      '{9'd5,   3'd0, 1'b0, 4'd1, 9'd5},
      '{9'd6,   3'd1, 1'b0, 4'd2, 9'd7},
      '{9'd7,   3'd1, 1'b0, 4'd2, 9'd6},
      '{9'd13,  3'd2, 1'b0, 4'd4, 9'd12},
      '{9'd13,  3'd2, 1'b1, 4'd4, 9'd14},
      '{9'd509, 3'd3, 1'b0, 4'd8, 9'd508},
      '{9'd509, 3'd3, 1'b1, 4'd8, 9'd506},
      '{9'd100, 3'd5, 1'b1, 4'd1, 9'd100},
      '{9'd3,   3'd1, 1'b1, 4'd2, 9'd2}
   };

   function automatic logic [8:0] exp_col(logic [8:0] s, logic [2:0] l, bit i, int k);
      logic [8:0] m;
      logic [8:0] kk;
      kk = 9'(k);
      case (l)
         3'd1: m = 9'd1;
         3'd2: m = 9'd3;
         3'd3: m = 9'd7;
         default: m = 9'd0;
      endcase
      if (l == 3'd7) return s + kk;
      return (s & ~m) | ((i ? (s ^ kk) : (s + kk)) & m);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic issue(input logic [8:0] s, input logic [2:0] l, input bit i);
      cmd_valid = 1'b1; start_col = s; burst_len = l; interleave = i;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   initial begin
      #(HALF * 2.0 * 200000.0);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(beat_valid == 1'b0, "R1", "beat_valid in reset", int'(beat_valid), 0);
      chk(last_beat == 1'b0, "R1", "last_beat in reset", int'(last_beat), 0);
      chk(col == 9'd0, "R1", "col in reset", int'(col), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(beat_valid == 1'b0 && col == 9'd0, "R1", "idle after reset", int'(col), 0);

      // Table-driven bursts: R2 R3 R4 R5 R7 R10
      foreach (VECS[v]) begin
         issue(VECS[v].start, VECS[v].len, VECS[v].ilv);
         chk(beat_valid && col == VECS[v].start, "R2", "first beat column",
             int'(col), int'(VECS[v].start));
         for (int k = 0; k < int'(VECS[v].beats); k++) begin
            logic [8:0] e;
            e = exp_col(VECS[v].start, VECS[v].len, VECS[v].ilv, k);
            chk(beat_valid == 1'b1, "R3", "beat valid", int'(beat_valid), 1);
            chk(col == e, VECS[v].ilv ? "R5" : "R4", "beat column", int'(col), int'(e));
            chk(last_beat == (k == int'(VECS[v].beats) - 1), "R7", "last_beat flag",
                int'(last_beat), int'(k == int'(VECS[v].beats) - 1));
            if (k < int'(VECS[v].beats) - 1) @(negedge clk);
         end
         @(negedge clk);
         chk(beat_valid == 1'b0, "R3", "burst ended", int'(beat_valid), 0);
         chk(col == VECS[v].final_col, "R10", "col holds after burst",
             int'(col), int'(VECS[v].final_col));
         @(negedge clk);
         chk(beat_valid == 1'b0 && col == VECS[v].final_col, "R10", "still idle",
             int'(col), int'(VECS[v].final_col));
      end

      // R8: terminate during an 8-beat burst after beat 1
      issue(9'd40, 3'd3, 1'b0);
      @(negedge clk);
      chk(col == 9'd41, "R8", "beat 1 column", int'(col), 41);
      term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      chk(beat_valid == 1'b0, "R8", "terminated", int'(beat_valid), 0);
      chk(col == 9'd41, "R8", "col after terminate", int'(col), 41);
      // R8: terminate while idle has no effect
      term = 1'b1;
      repeat (2) @(negedge clk);
      term = 1'b0;
      chk(beat_valid == 1'b0 && last_beat == 1'b0, "R8", "idle terminate", int'(beat_valid), 0);
      chk(col == 9'd41, "R8", "idle terminate col", int'(col), 41);

      // R9: restart mid-burst with new column, length and order
      issue(9'd200, 3'd3, 1'b0);
      @(negedge clk);
      chk(col == 9'd201, "R9", "old burst beat 1", int'(col), 201);
      issue(9'd300, 3'd1, 1'b1);
      chk(beat_valid && col == 9'd300 && !last_beat, "R9", "restart beat 0", int'(col), 300);
      @(negedge clk);
      chk(beat_valid && col == 9'd301 && last_beat, "R9", "restart beat 1", int'(col), 301);
      @(negedge clk);
      chk(beat_valid == 1'b0, "R9", "restarted burst length", int'(beat_valid), 0);

      // R9: command and terminate together, command wins
      issue(9'd64, 3'd2, 1'b0);
      term = 1'b1;
      issue(9'd80, 3'd2, 1'b0);
      term = 1'b0;
      chk(beat_valid && col == 9'd80, "R9", "command beats terminate", int'(col), 80);
      @(negedge clk);
      chk(beat_valid && col == 9'd81, "R9", "burst continues", int'(col), 81);
      repeat (3) @(negedge clk);
      chk(beat_valid == 1'b0, "R9", "burst of four done", int'(beat_valid), 0);

      // R6: full page wraps past 511, interleave ignored, no last_beat
      begin
         int bad_col = 0;
         int bad_flag = 0;
         issue(9'd508, 3'd7, 1'b1);
         for (int k = 0; k < 520; k++) begin
            if (col != 9'((508 + k) % 512) || !beat_valid) bad_col++;
            if (last_beat) bad_flag++;
            @(negedge clk);
         end
         chk(bad_col == 0, "R6", "full page columns wrong", bad_col, 0);
         chk(bad_flag == 0, "R7", "last_beat in full page", bad_flag, 0);
         chk(beat_valid && col == 9'd4, "R6", "still running", int'(col), 4);
         term = 1'b1;
         @(negedge clk);
         term = 1'b0;
         chk(beat_valid == 1'b0 && col == 9'd4, "R6", "stopped by terminate", int'(col), 4);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule